// File: doc/BRIEF.md
# Serial Configuration Stream Parser

This block takes a serial configuration stream, one bit per clock cycle, with a data bit and a qualifying strobe. It locks onto the header, which is made of a run of ones, a four-bit sync code, a 24-bit total length sent most significant bit first, and a run of separator ones. It then cuts the body into a fixed number of frames of fixed size. Each data bit of a frame is presented on an output with a one-cycle strobe and the index of its frame. The four trailer bits of each frame are checked. The stream must close with an eight-bit postamble.

Any violation stops the parse. The active-low error output then goes low and stays low until the next reset, which plays the role of the program pulse. A clean stream ends with a single done pulse.

The stream has two checking modes. In fixed-trailer mode every frame trailer must carry a set pattern, and extra ones may pad the gap after any frame. In CRC mode the trailer is passed over without a check, and no padding is allowed between frames. The CRC itself is not computed here. The frame size and the frame count are elaboration parameters.

Top module: `cfg_stream_parser`

## Requirements
- R1: The stream must open with at least eight consecutive '1' bits, and any larger number is accepted. A '0' that arrives after fewer than eight ones is an error.
- R2: The first '0' after the leading ones begins the sync code 0010, in arrival order. Any other value in the next three bits is an error.
- R3: The 24 bits that follow the sync code are the length, first received bit as the MSB. The captured value is shown on `stream_len` from the cycle after its last bit.
- R4: At least four '1' bits follow the length, and more are accepted. A '0' after fewer than four ones is an error. A '0' after four or more ones is the start bit of frame 0.
- R5: After each start bit, the next FRAME_BITS bits are data. Each data bit appears on `frame_bit` with `frame_bit_vld` high for one cycle, the cycle after it is accepted. `frame_idx` gives the 0-based frame number.
- R6: In fixed-trailer mode (`crc_mode`=0), the four bits after the data must be 0, 1, 1, 0 in arrival order. Any mismatch is an error.
- R7: After a trailer in fixed-trailer mode, '1' bits are skipped and the next '0' is a start bit. In CRC mode (`crc_mode`=1), trailer bits are not checked, and a '1' where a start bit is due is an error.
- R8: After the trailer of frame NUM_FRAMES-1 (and any allowed padding), the postamble must be a '0' followed by seven '1' bits. A '0' among those seven is an error.
- R9: Accepted bits are numbered from 1, starting with the first header bit. The last postamble bit must be exactly bit number `stream_len`. The stream is an error if the count is reached earlier, if the postamble ends earlier, or if the length is too small to extend past the length field itself.
- R10: On an error, `err_n` goes low in the next cycle and stays low until reset. After an error no further `frame_bit_vld` or `done` is produced.
- R11: `done` pulses for exactly one cycle, the cycle after the last postamble bit of a valid stream. All later input is ignored until reset.
- R12: While `bit_vld` is low, `bit_in` has no effect.
- R13: After reset, `err_n` is 1, and `done`, `frame_bit_vld` and `stream_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the parse |
| bit_in | input | 1 | Serial stream bit |
| bit_vld | input | 1 | Qualifies bit_in |
| crc_mode | input | 1 | 0: fixed trailer check with padding; 1: trailer unchecked, no padding |
| frame_bit | output | 1 | Frame data bit |
| frame_bit_vld | output | 1 | frame_bit is valid this cycle |
| frame_idx | output | IDX_W | Frame number of frame_bit |
| stream_len | output | 24 | Captured length |
| done | output | 1 | One-cycle pulse at a valid end of stream |
| err_n | output | 1 | Low after any error, sticky until reset |

## Verification
Some properties are checked on every cycle. The error output is sticky. No frame data or done is produced once the error output is low. Done is a single-cycle pulse that never coincides with an error. Frame strobes and done only follow an accepted input bit, and the frame index stays in range.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the header, separator and padding lengths that are accepted or refused;
- the trailer and postamble patterns;
- the exact length accounting;
- the value and order of the frame data;
- input being ignored after done or after an error.

The bench sweeps these over a three-frame, five-bit configuration.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and state type for the configuration stream parser.
// Assumes: code patterns are listed with the first-received bit as the MSB.
package cfgp_pkg;
    localparam int LEN_W     = 24;
    localparam int MIN_LEAD  = 8;
    localparam int MIN_SEP   = 4;
    localparam int POST_ONES = 7;
    localparam logic [3:0] SYNC_CODE    = 4'b0010;
    localparam logic [3:0] TRAILER_CODE = 4'b0110;

    typedef enum logic [3:0] {
        ST_LEAD, ST_SYNC, ST_LEN, ST_SEP, ST_DATA,
        ST_CHK, ST_GAP, ST_POST, ST_DONE, ST_HALT
    } cfgp_state_e;
endpackage

// File: rtl/cfgp_len_track.sv
// Module: counts accepted stream bits and tracks how many remain under the
// captured length.
// Assumes: 'take' marks each accepted bit, and 'load' is high together with
// 'take' on the last length bit.
module cfgp_len_track
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             short_load,
    output logic             last_bit,
    output logic [LEN_W-1:0] len_q
);
    logic [LEN_W-1:0] seen;
    logic [LEN_W-1:0] rem;
    logic             loaded;
    logic [LEN_W:0]   seen_incl;

    // Purpose: number of bits counted so far, including the current one.
    always_comb seen_incl = {1'b0, seen} + {{LEN_W{1'b0}}, 1'b1};

    // Purpose: flag a length that ends at or before the current bit.
    always_comb short_load = load && ({1'b0, load_val} <= seen_incl);

    // Purpose: the current bit is the final bit allowed by the length.
    always_comb last_bit = loaded && (rem == {{(LEN_W-1){1'b0}}, 1'b1});

    // Purpose: saturating bit counter, remaining budget and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen   <= '0;
            rem    <= '0;
            loaded <= 1'b0;
            len_q  <= '0;
        end else if (take) begin
            if (!(&seen)) seen <= seen + 1'b1;
            if (load && !short_load) begin
                rem    <= load_val - seen_incl[LEN_W-1:0];
                loaded <= 1'b1;
                len_q  <= load_val;
            end else if (loaded && rem != '0) begin
                rem <= rem - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgp_seq.sv
// Module: bit-level sequencer. Walks the header, the frames and the
// postamble, and raises one-cycle pulses for frame data, done and error.
// Assumes: crc_mode is held stable for the whole stream; the length tracker
// reports on the same accepted bit, combinationally.
module cfgp_seq
    import cfgp_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int NUM_FRAMES = 32,
    parameter int IDX_W      = 5,
    parameter int CNT_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             crc_mode,
    input  logic             len_short,
    input  logic             len_last,
    output logic             take,
    output logic             len_load,
    output logic [LEN_W-1:0] len_val,
    output logic             data_p,
    output logic [IDX_W-1:0] idx_p,
    output logic             done_p,
    output logic             err_p
);
    cfgp_state_e        state, state_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [IDX_W-1:0]   frame, frame_n;
    logic [LEN_W-2:0]   shreg, shreg_n;
    logic [1:0]         sel;
    logic               bad;
    logic               finishing;

    // Purpose: a bit is consumed unless the parse has ended.
    always_comb take = bit_vld && (state != ST_DONE) && (state != ST_HALT);

    // Purpose: position inside a 4-bit code field.
    always_comb sel = cnt[1:0];

    // Purpose: the length value presented on the last length bit.
    always_comb len_val = {shreg, bit_in};

    // Purpose: next-state, counters and the pulses for the output stage.
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        frame_n   = frame;
        shreg_n   = shreg;
        bad       = 1'b0;
        finishing = 1'b0;
        len_load  = 1'b0;
        data_p    = 1'b0;
        done_p    = 1'b0;
        idx_p     = frame;
        if (take) begin
            unique case (state)
                ST_LEAD: begin
                    if (bit_in) begin
                        if (cnt < CNT_W'(MIN_LEAD)) cnt_n = cnt + 1'b1;
                    end else if (cnt >= CNT_W'(MIN_LEAD)) begin
                        state_n = ST_SYNC;
                        cnt_n   = CNT_W'(1);
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (bit_in != SYNC_CODE[2'd3 - sel]) begin
                        bad = 1'b1;
                    end else if (sel == 2'd3) begin
                        state_n = ST_LEN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_LEN: begin
                    shreg_n = {shreg[LEN_W-3:0], bit_in};
                    if (cnt == CNT_W'(LEN_W-1)) begin
                        len_load = 1'b1;
                        if (len_short) begin
                            bad = 1'b1;
                        end else begin
                            state_n = ST_SEP;
                            cnt_n   = '0;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_SEP: begin
                    if (bit_in) begin
                        if (cnt < CNT_W'(MIN_SEP)) cnt_n = cnt + 1'b1;
                    end else if (cnt >= CNT_W'(MIN_SEP)) begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                        frame_n = '0;
                    end else begin
                        bad = 1'b1;
                    end
                end
                ST_DATA: begin
                    data_p = 1'b1;
                    if (cnt == CNT_W'(FRAME_BITS-1)) begin
                        state_n = ST_CHK;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_CHK: begin
                    if (!crc_mode && (bit_in != TRAILER_CODE[2'd3 - sel])) begin
                        bad = 1'b1;
                    end else if (sel == 2'd3) begin
                        state_n = ST_GAP;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (bit_in) begin
                        if (crc_mode) bad = 1'b1;
                    end else if (frame == IDX_W'(NUM_FRAMES-1)) begin
                        state_n = ST_POST;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                        frame_n = frame + 1'b1;
                    end
                end
                ST_POST: begin
                    if (!bit_in) begin
                        bad = 1'b1;
                    end else if (cnt == CNT_W'(POST_ONES-1)) begin
                        finishing = 1'b1;
                        state_n   = ST_DONE;
                        done_p    = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: ;
            endcase
            if (len_last != finishing) bad = 1'b1;
            if (bad) begin
                state_n = ST_HALT;
                data_p  = 1'b0;
                done_p  = 1'b0;
            end
        end
        err_p = bad;
    end

    // Purpose: sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LEAD;
            cnt   <= '0;
            frame <= '0;
            shreg <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            frame <= frame_n;
            shreg <= shreg_n;
        end
    end
endmodule

// File: rtl/cfgp_out_stage.sv
// Module: registers the sequencer pulses onto the block outputs and holds
// the sticky error flag.
// Assumes: the pulses last one cycle and are qualified by the sequencer.
module cfgp_out_stage #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             data_p,
    input  logic [IDX_W-1:0] idx_p,
    input  logic             done_p,
    input  logic             err_p,
    output logic             frame_bit,
    output logic             frame_bit_vld,
    output logic [IDX_W-1:0] frame_idx,
    output logic             done,
    output logic             err_n
);
    // Purpose: output registers; err_n only clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_bit     <= 1'b0;
            frame_bit_vld <= 1'b0;
            frame_idx     <= '0;
            done          <= 1'b0;
            err_n         <= 1'b1;
        end else begin
            frame_bit_vld <= data_p;
            done          <= done_p;
            err_n         <= err_n & ~err_p;
            if (data_p) begin
                frame_bit <= bit_in;
                frame_idx <= idx_p;
            end
        end
    end
endmodule

// File: rtl/cfg_stream_parser.sv
// Module: top of the serial configuration stream parser. Ties together the
// sequencer, the length tracker and the output stage.
// Assumes: one bit per qualified cycle; reset restarts the parse.
module cfg_stream_parser
    import cfgp_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int NUM_FRAMES = 32,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_MAX   = (FRAME_BITS > LEN_W) ? FRAME_BITS : LEN_W,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             crc_mode,
    output logic             frame_bit,
    output logic             frame_bit_vld,
    output logic [IDX_W-1:0] frame_idx,
    output logic [LEN_W-1:0] stream_len,
    output logic             done,
    output logic             err_n
);
    logic             take, len_load, len_short, len_last;
    logic [LEN_W-1:0] len_val;
    logic             data_p, done_p, err_p;
    logic [IDX_W-1:0] idx_p;

    cfgp_seq #(
        .FRAME_BITS (FRAME_BITS),
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .crc_mode  (crc_mode),
        .len_short (len_short),
        .len_last  (len_last),
        .take      (take),
        .len_load  (len_load),
        .len_val   (len_val),
        .data_p    (data_p),
        .idx_p     (idx_p),
        .done_p    (done_p),
        .err_p     (err_p)
    );

    cfgp_len_track u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .load       (len_load),
        .load_val   (len_val),
        .short_load (len_short),
        .last_bit   (len_last),
        .len_q      (stream_len)
    );

    cfgp_out_stage #(.IDX_W(IDX_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_in        (bit_in),
        .data_p        (data_p),
        .idx_p         (idx_p),
        .done_p        (done_p),
        .err_p         (err_p),
        .frame_bit     (frame_bit),
        .frame_bit_vld (frame_bit_vld),
        .frame_idx     (frame_idx),
        .done          (done),
        .err_n         (err_n)
    );
endmodule

// File: rtl/cfg_stream_parser_chk.sv
// Module: property checker bound to the parser top; observes ports only.
// Assumes: synchronous active-low reset.
module cfg_stream_parser_chk #(
    parameter int NUM_FRAMES = 32,
    parameter int IDX_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_in,
    input logic             bit_vld,
    input logic             frame_bit_vld,
    input logic [IDX_W-1:0] frame_idx,
    input logic             done,
    input logic             err_n
);
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |=> !err_n);
    assert_no_data_after_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> !frame_bit_vld);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> err_n);
    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bit_vld |-> (frame_idx <= IDX_W'(NUM_FRAMES-1)));
    assert_data_needs_vld_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bit_vld |-> $past(bit_vld));
    assert_done_after_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bit_vld) && $past(bit_in)));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_in        (bit_in),
    .bit_vld       (bit_vld),
    .frame_bit_vld (frame_bit_vld),
    .frame_idx     (frame_idx),
    .done          (done),
    .err_n         (err_n)
);

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 5;
    localparam int NF = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic crc_mode = 1'b0;
    logic frame_bit, frame_bit_vld, done, err_n;
    logic [IW-1:0] frame_idx;
    logic [23:0] stream_len;

    cfg_stream_parser #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .crc_mode(crc_mode), .frame_bit(frame_bit), .frame_bit_vld(frame_bit_vld),
        .frame_idx(frame_idx), .stream_len(stream_len), .done(done), .err_n(err_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic sbits [0:255];
    int slen = 0;
    int last_len = 0;
    int f0 = 0;
    logic mon_bits [0:63];
    int mon_idx [0:63];
    int mon_n = 0;
    int done_cnt = 0;

    // Monitor: collects outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_bit_vld) begin
                if (mon_n < 64) begin
                    mon_bits[mon_n] = frame_bit;
                    mon_idx[mon_n]  = int'(frame_idx);
                end
                mon_n++;
            end
            if (done) done_cnt++;
        end
    end

    function automatic logic dbit(int s, int f, int j);
        return ((s + f*11 + j*j + (s/2)*j) % 3) == 1;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic b);
        sbits[slen] = b;
        slen++;
    endtask

    // Builds a stream; len_ovr >= 0 forces the length field value.
    task automatic build(input int lead, input int sep, input int gap, input int s,
                         input logic crc, input int len_adj, input int len_ovr);
        int lpos;
        slen = 0;
        for (int i = 0; i < lead; i++) put(1'b1);
        put(1'b0); put(1'b0); put(1'b1); put(1'b0);
        lpos = slen;
        for (int i = 0; i < 24; i++) put(1'b0);
        for (int i = 0; i < sep; i++) put(1'b1);
        f0 = slen;
        for (int f = 0; f < NF; f++) begin
            put(1'b0);
            for (int j = 0; j < FB; j++) put(dbit(s, f, j));
            if (crc) begin
                for (int c = 0; c < 4; c++) put(logic'(((9 ^ f) >> (3 - c)) & 1));
            end else begin
                put(1'b0); put(1'b1); put(1'b1); put(1'b0);
            end
            for (int g = 0; g < gap; g++) put(1'b1);
        end
        put(1'b0);
        for (int i = 0; i < 7; i++) put(1'b1);
        last_len = (len_ovr >= 0) ? len_ovr : slen + len_adj;
        for (int i = 0; i < 24; i++) sbits[lpos + i] = logic'((last_len >> (23 - i)) & 1);
    endtask

    // Feeds the stream with idle cycles carrying junk on bit_in (R12).
    task automatic feed(input int s);
        for (int i = 0; i < slen; i++) begin
            if ((i*7 + s) % 5 == 0) begin
                @(negedge clk);
                bit_vld = 1'b0;
                bit_in  = ~sbits[i];
            end
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = sbits[i];
        end
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_vld = 1'b0;
        repeat (2) @(negedge clk);
        mon_n = 0;
        done_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic check_pass(input int s);
        int bad_d = 0;
        int bad_i = 0;
        chk(err_n == 1'b1, "R10", "err_n on valid stream", int'(err_n), 1);
        chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
        chk(mon_n == NF*FB, "R5", "frame bits out", mon_n, NF*FB);
        for (int k = 0; k < NF*FB && k < mon_n; k++) begin
            if (mon_bits[k] !== dbit(s, k / FB, k % FB)) bad_d++;
            if (mon_idx[k] != k / FB) bad_i++;
        end
        chk(bad_d == 0, "R5", "data bit mismatches", bad_d, 0);
        chk(bad_i == 0, "R5", "frame index mismatches", bad_i, 0);
        chk(int'(stream_len) == last_len, "R3", "captured length", int'(stream_len), last_len);
    endtask

    task automatic check_fail(input string req, input int exp_bits);
        chk(err_n == 1'b0, req, "err_n after bad stream", int'(err_n), 0);
        chk(done_cnt == 0, req, "done on bad stream", done_cnt, 0);
        chk(mon_n == exp_bits, req, "frame bits before halt", mon_n, exp_bits);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed = 0;
        do_reset();
        @(negedge clk);
        // R13 reset state
        chk(err_n == 1'b1, "R13", "err_n after reset", int'(err_n), 1);
        chk(done == 1'b0, "R13", "done after reset", int'(done), 0);
        chk(frame_bit_vld == 1'b0, "R13", "frame_bit_vld after reset", int'(frame_bit_vld), 0);
        chk(stream_len == 24'd0, "R13", "stream_len after reset", int'(stream_len), 0);

        // R1 R4 R7 R9: sweep of valid streams, fixed-trailer mode with padding
        crc_mode = 1'b0;
        for (int lead = 8; lead <= 10; lead++)
            for (int sep = 4; sep <= 5; sep++)
                for (int gap = 0; gap <= 2; gap++) begin
                    seed++;
                    do_reset();
                    build(lead, sep, gap, seed, 1'b0, 0, -1);
                    feed(seed);
                    check_pass(seed);
                end

        // R7: CRC mode, trailers unchecked, no padding
        crc_mode = 1'b1;
        for (int lead = 8; lead <= 10; lead++)
            for (int sep = 4; sep <= 5; sep++) begin
                seed++;
                do_reset();
                build(lead, sep, 0, seed, 1'b1, 0, -1);
                feed(seed);
                check_pass(seed);
            end

        // R11: input after done is ignored
        build(9, 4, 0, 77, 1'b1, 0, -1);
        feed(3);
        chk(done_cnt == 1, "R11", "done pulses after extra stream", done_cnt, 1);
        chk(mon_n == NF*FB, "R11", "frame bits after extra stream", mon_n, NF*FB);
        chk(err_n == 1'b1, "R11", "err_n after extra stream", int'(err_n), 1);

        // R7: a '1' where a start bit is due in CRC mode
        do_reset();
        build(8, 4, 1, 5, 1'b1, 0, -1);
        feed(5);
        check_fail("R7", FB);

        crc_mode = 1'b0;
        // R1: only seven leading ones
        do_reset();
        build(7, 4, 0, 6, 1'b0, 0, -1);
        feed(6);
        check_fail("R1", 0);

        // R2: sync code corrupted in each of its last three bits
        for (int p = 1; p <= 3; p++) begin
            do_reset();
            build(8, 4, 0, 7, 1'b0, 0, -1);
            sbits[8 + p] = ~sbits[8 + p];
            feed(7);
            check_fail("R2", 0);
        end

        // R4: only three separator ones
        do_reset();
        build(8, 3, 0, 8, 1'b0, 0, -1);
        feed(8);
        check_fail("R4", 0);

        // R6: each trailer bit of frame 1 corrupted
        for (int c = 0; c < 4; c++) begin
            do_reset();
            build(8, 4, 1, 9, 1'b0, 0, -1);
            sbits[f0 + (1 + FB + 4 + 1) + 1 + FB + c] = ~sbits[f0 + (1 + FB + 4 + 1) + 1 + FB + c];
            feed(9);
            check_fail("R6", 2*FB);
        end

        // R8: a postamble one turned to zero
        for (int k = 0; k < 7; k += 3) begin
            do_reset();
            build(8, 4, 0, 10, 1'b0, 0, -1);
            sbits[slen - 1 - k] = 1'b0;
            feed(10);
            check_fail("R8", NF*FB);
        end

        // R9: length one too long, one too short, and shorter than the header
        do_reset();
        build(8, 4, 0, 11, 1'b0, 1, -1);
        feed(11);
        check_fail("R9", NF*FB);
        do_reset();
        build(8, 4, 0, 12, 1'b0, -1, -1);
        feed(12);
        check_fail("R9", NF*FB);
        do_reset();
        build(8, 4, 0, 13, 1'b0, 0, 36);
        feed(13);
        check_fail("R9", 0);

        // R10: a valid stream after an error, without reset, changes nothing
        build(8, 4, 0, 14, 1'b0, 0, -1);
        feed(14);
        check_fail("R10", 0);

        // R13: reset clears the error, and a valid stream then passes
        do_reset();
        @(negedge clk);
        chk(err_n == 1'b1, "R13", "err_n after reset pulse", int'(err_n), 1);
        build(11, 6, 2, 15, 1'b0, 0, -1);
        feed(15);
        check_pass(15);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule